// File: doc/BRIEF.md
# TCP Endpoint Control Request Handler

This block serves the control side of a small hardware TCP endpoint. An application opens a connection by naming a remote IPv4 address and port. The block answers with a session number and a success flag, taking the number from a fixed session table. A session counts as established as soon as it is allocated. The application ends a session by sending its number on a close stream. The close stream never answers, and the entry is freed in the cycle the close is taken. A third stream registers local ports as listening. Each such request gets a single pass or fail answer. Only ports below a configured limit may listen, and the limit defaults to 32768.

Every stream uses a valid/ready handshake. Only one open request and one listen request are in service at a time, so responses come back in request order. The handshake with the peer, retransmission and packet handling all happen elsewhere. A synchronous active-high reset empties the session table and the listening-port table.

Top module: `conn_req_ctrl`

## Requirements
- R1: An accepted open request produces exactly one response, which becomes valid in the cycle after acceptance. The response holds its session number and flag stable until it is accepted. No new open request is accepted while a response is pending.
- R2: A successful open returns flag 1 together with the lowest-numbered free session, from 0 to 15. That session becomes in use.
- R3: When all 16 sessions are in use, an open request returns flag 0 and session number 0.
- R4: An open request whose address and port both equal those of a session in use returns flag 0 and session number 0. It allocates nothing.
- R5: The close stream is always ready and never produces a response. A close of a session in use frees it, so a later open can receive that session number again.
- R6: A close that names a free session, or a number of 16 or above, changes no session.
- R7: A listen request for a port of 32768 or above, meaning bit 15 is set, returns 0. The port is not recorded.
- R8: A listen request for an in-range port that is not yet listening returns 1 and records the port. Its response is valid in the cycle after acceptance and held until accepted.
- R9: A listen request for a port that is already listening returns 0 and leaves the recorded ports unchanged.
- R10: The table holds 8 listening ports. Once it is full, any further in-range listen request returns 0.
- R11: Reset clears all sessions and all listening ports, and leaves both response streams not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| open_req_valid | input | 1 | Open request valid |
| open_req_ready | output | 1 | Open request accepted this cycle |
| open_req_addr | input | 32 | Remote IPv4 address |
| open_req_port | input | 16 | Remote TCP port |
| open_rsp_valid | output | 1 | Open response valid |
| open_rsp_ready | input | 1 | Open response taken |
| open_rsp_sid | output | 16 | Allocated session number, 0 on failure |
| open_rsp_ok | output | 1 | 1 when a session was allocated |
| close_req_valid | input | 1 | Close request valid |
| close_req_ready | output | 1 | Close request accepted, always 1 |
| close_req_sid | input | 16 | Session number to free |
| lsn_req_valid | input | 1 | Listen request valid |
| lsn_req_ready | output | 1 | Listen request accepted this cycle |
| lsn_req_port | input | 16 | Local port to listen on |
| lsn_rsp_valid | output | 1 | Listen response valid |
| lsn_rsp_ready | input | 1 | Listen response taken |
| lsn_rsp_ok | output | 1 | 1 when the port was recorded |

## Verification
The assertions check the protocol on every cycle: each accepted request gets a response in the next cycle, a pending response stays stable, a failed open always reports session 0, a successful session number is inside the table, an out-of-range listen port always fails, and both streams are idle after reset. Some results depend on earlier history, and only the directed scenarios show them. These are lowest-free allocation, reuse of a closed session, rejection of a duplicate tuple, and a full table. They also include closes that must be ignored, with out-of-range numbers that alias a live entry, along with duplicate and overflow listen requests and the clearing done by a second reset.

// File: rtl/conn_req_pkg.sv
package conn_req_pkg;
   localparam int unsigned ADDR_W = 32;
   localparam int unsigned PORT_W = 16;

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic [PORT_W-1:0] port;
   } dest_t;
endpackage

// File: rtl/crq_first_free.sv
module crq_first_free #(
   parameter  int unsigned N = 16,
   localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] busy,
   output logic         found,
   output logic [W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!busy[i]) begin
            found = 1'b1;
            idx   = W'(i);
         end
      end
   end
endmodule

// File: rtl/crq_sess_table.sv
module crq_sess_table
   import conn_req_pkg::*;
#(
   parameter  int unsigned N     = 16,
   localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  dest_t            req_dst,
   input  logic             alloc_en,
   input  logic             free_en,
   input  logic [IDX_W-1:0] free_idx,
   output logic             slot_found,
   output logic [IDX_W-1:0] slot_idx,
   output logic             dup_hit
);
   logic [N-1:0] busy;
   logic [N-1:0] match;

   crq_first_free #(.N(N)) u_pick (
      .busy  (busy),
      .found (slot_found),
      .idx   (slot_idx)
   );

   for (genvar g = 0; g < N; g++) begin : g_entry
      dest_t dst_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            busy[g] <= 1'b0;
         end else if (alloc_en && slot_idx == IDX_W'(g)) begin
            busy[g] <= 1'b1;
         end else if (free_en && free_idx == IDX_W'(g)) begin
            busy[g] <= 1'b0;
         end
      end
      always_ff @(posedge clk) begin
         if (alloc_en && slot_idx == IDX_W'(g)) dst_q <= req_dst;
      end
      assign match[g] = busy[g] && (dst_q == req_dst);
   end

   assign dup_hit = |match;
endmodule

// File: rtl/crq_listen_table.sv
module crq_listen_table #(
   parameter  int unsigned SLOTS  = 8,
   parameter  int unsigned PORT_W = 16,
   parameter  int unsigned LIMIT  = 32768,
   localparam int unsigned IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PORT_W-1:0] q_port,
   input  logic              wr_en,
   output logic              in_range,
   output logic              hit,
   output logic              has_room
);
   logic [SLOTS-1:0] used;
   logic [SLOTS-1:0] match;
   logic [IDX_W-1:0] wr_idx;

   crq_first_free #(.N(SLOTS)) u_pick (
      .busy  (used),
      .found (has_room),
      .idx   (wr_idx)
   );

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic [PORT_W-1:0] port_q;
      always_ff @(posedge clk) begin
         if (rst) used[g] <= 1'b0;
         else if (wr_en && wr_idx == IDX_W'(g)) used[g] <= 1'b1;
      end
      always_ff @(posedge clk) begin
         if (wr_en && wr_idx == IDX_W'(g)) port_q <= q_port;
      end
      assign match[g] = used[g] && (port_q == q_port);
   end

   assign hit      = |match;
   assign in_range = 32'(q_port) < LIMIT;
endmodule

// File: rtl/conn_req_ctrl.sv
module conn_req_ctrl
   import conn_req_pkg::*;
#(
   parameter  int unsigned SESS_NUM       = 16,
   parameter  int unsigned SID_W          = 16,
   parameter  int unsigned LSN_SLOTS      = 8,
   parameter  int unsigned LSN_PORT_LIMIT = 32768,
   localparam int unsigned SESS_IDX_W     = (SESS_NUM > 1) ? $clog2(SESS_NUM) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              open_req_valid,
   output logic              open_req_ready,
   input  logic [ADDR_W-1:0] open_req_addr,
   input  logic [PORT_W-1:0] open_req_port,
   output logic              open_rsp_valid,
   input  logic              open_rsp_ready,
   output logic [SID_W-1:0]  open_rsp_sid,
   output logic              open_rsp_ok,
   input  logic              close_req_valid,
   output logic              close_req_ready,
   input  logic [SID_W-1:0]  close_req_sid,
   input  logic              lsn_req_valid,
   output logic              lsn_req_ready,
   input  logic [PORT_W-1:0] lsn_req_port,
   output logic              lsn_rsp_valid,
   input  logic              lsn_rsp_ready,
   output logic              lsn_rsp_ok
);
   if (SESS_NUM < 2 || SESS_NUM >= (64'd1 << SID_W)) begin : g_bad_sess
      $error("conn_req_ctrl: SESS_NUM must be at least 2 and below 2**SID_W");
   end
   if (LSN_SLOTS < 1) begin : g_bad_slots
      $error("conn_req_ctrl: LSN_SLOTS must be at least 1");
   end
   if (PORT_W > 32 || LSN_PORT_LIMIT > (64'd1 << PORT_W)) begin : g_bad_limit
      $error("conn_req_ctrl: LSN_PORT_LIMIT exceeds the port space");
   end

   // open / close path
   dest_t                 req_dst;
   logic                  open_fire, open_ok_c, close_en;
   logic                  slot_found, dup_hit;
   logic [SESS_IDX_W-1:0] slot_idx;

   assign req_dst        = '{addr: open_req_addr, port: open_req_port};
   assign open_req_ready = !open_rsp_valid;
   assign open_fire      = open_req_valid && open_req_ready;
   assign open_ok_c      = slot_found && !dup_hit;
   assign close_req_ready = 1'b1;
   assign close_en       = close_req_valid && (close_req_sid < SID_W'(SESS_NUM));

   crq_sess_table #(.N(SESS_NUM)) u_sess (
      .clk        (clk),
      .rst        (rst),
      .req_dst    (req_dst),
      .alloc_en   (open_fire && open_ok_c),
      .free_en    (close_en),
      .free_idx   (close_req_sid[SESS_IDX_W-1:0]),
      .slot_found (slot_found),
      .slot_idx   (slot_idx),
      .dup_hit    (dup_hit)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         open_rsp_valid <= 1'b0;
         open_rsp_sid   <= '0;
         open_rsp_ok    <= 1'b0;
      end else if (open_fire) begin
         open_rsp_valid <= 1'b1;
         open_rsp_ok    <= open_ok_c;
         open_rsp_sid   <= open_ok_c ? SID_W'(slot_idx) : '0;
      end else if (open_rsp_ready) begin
         open_rsp_valid <= 1'b0;
      end
   end

   // listen path
   logic lsn_fire, lsn_in_range, lsn_hit, lsn_room, lsn_ok_c;

   assign lsn_req_ready = !lsn_rsp_valid;
   assign lsn_fire      = lsn_req_valid && lsn_req_ready;
   assign lsn_ok_c      = lsn_in_range && !lsn_hit && lsn_room;

   crq_listen_table #(
      .SLOTS  (LSN_SLOTS),
      .PORT_W (PORT_W),
      .LIMIT  (LSN_PORT_LIMIT)
   ) u_lsn (
      .clk      (clk),
      .rst      (rst),
      .q_port   (lsn_req_port),
      .wr_en    (lsn_fire && lsn_ok_c),
      .in_range (lsn_in_range),
      .hit      (lsn_hit),
      .has_room (lsn_room)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         lsn_rsp_valid <= 1'b0;
         lsn_rsp_ok    <= 1'b0;
      end else if (lsn_fire) begin
         lsn_rsp_valid <= 1'b1;
         lsn_rsp_ok    <= lsn_ok_c;
      end else if (lsn_rsp_ready) begin
         lsn_rsp_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/conn_req_ctrl_chk.sv
module conn_req_ctrl_chk #(
   parameter int unsigned SESS_NUM       = 16,
   parameter int unsigned SID_W          = 16,
   parameter int unsigned PORT_W         = 16,
   parameter int unsigned LSN_PORT_LIMIT = 32768
) (
   input logic              clk,
   input logic              rst,
   input logic              open_req_valid,
   input logic              open_req_ready,
   input logic              open_rsp_valid,
   input logic              open_rsp_ready,
   input logic [SID_W-1:0]  open_rsp_sid,
   input logic              open_rsp_ok,
   input logic              lsn_req_valid,
   input logic              lsn_req_ready,
   input logic [PORT_W-1:0] lsn_req_port,
   input logic              lsn_rsp_valid,
   input logic              lsn_rsp_ready,
   input logic              lsn_rsp_ok
);
   p_open_rsp_next_r1: assert property (@(posedge clk) disable iff (rst)
      open_req_valid && open_req_ready |=> open_rsp_valid);

   p_open_rsp_hold_r1: assert property (@(posedge clk) disable iff (rst)
      open_rsp_valid && !open_rsp_ready |=>
         open_rsp_valid && $stable(open_rsp_sid) && $stable(open_rsp_ok));

   p_open_single_r1: assert property (@(posedge clk) disable iff (rst)
      open_rsp_valid |-> !open_req_ready);

   p_ok_sid_range_r2: assert property (@(posedge clk) disable iff (rst)
      open_rsp_valid && open_rsp_ok |-> open_rsp_sid < SID_W'(SESS_NUM));

   p_fail_sid_zero_r3: assert property (@(posedge clk) disable iff (rst)
      open_rsp_valid && !open_rsp_ok |-> open_rsp_sid == '0);

   p_lsn_range_r7: assert property (@(posedge clk) disable iff (rst)
      lsn_req_valid && lsn_req_ready && (32'(lsn_req_port) >= LSN_PORT_LIMIT)
         |=> lsn_rsp_valid && !lsn_rsp_ok);

   p_lsn_hold_r8: assert property (@(posedge clk) disable iff (rst)
      lsn_rsp_valid && !lsn_rsp_ready |=> lsn_rsp_valid && $stable(lsn_rsp_ok));

   p_reset_idle_r11: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !open_rsp_valid && !lsn_rsp_valid);
endmodule

bind conn_req_ctrl conn_req_ctrl_chk #(
   .SESS_NUM       (SESS_NUM),
   .SID_W          (SID_W),
   .PORT_W         (conn_req_pkg::PORT_W),
   .LSN_PORT_LIMIT (LSN_PORT_LIMIT)
) u_chk (
   .clk            (clk),
   .rst            (rst),
   .open_req_valid (open_req_valid),
   .open_req_ready (open_req_ready),
   .open_rsp_valid (open_rsp_valid),
   .open_rsp_ready (open_rsp_ready),
   .open_rsp_sid   (open_rsp_sid),
   .open_rsp_ok    (open_rsp_ok),
   .lsn_req_valid  (lsn_req_valid),
   .lsn_req_ready  (lsn_req_ready),
   .lsn_req_port   (lsn_req_port),
   .lsn_rsp_valid  (lsn_rsp_valid),
   .lsn_rsp_ready  (lsn_rsp_ready),
   .lsn_rsp_ok     (lsn_rsp_ok)
);

// File: tb/conn_req_ctrl_tb_top.sv
`timescale 1ns/1ps
module conn_req_ctrl_tb_top;
   localparam int NSESS = 16;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        open_req_valid = 1'b0;
   logic        open_req_ready;
   logic [31:0] open_req_addr = '0;
   logic [15:0] open_req_port = '0;
   logic        open_rsp_valid;
   logic        open_rsp_ready = 1'b0;
   logic [15:0] open_rsp_sid;
   logic        open_rsp_ok;
   logic        close_req_valid = 1'b0;
   logic        close_req_ready;
   logic [15:0] close_req_sid = '0;
   logic        lsn_req_valid = 1'b0;
   logic        lsn_req_ready;
   logic [15:0] lsn_req_port = '0;
   logic        lsn_rsp_valid;
   logic        lsn_rsp_ready = 1'b0;
   logic        lsn_rsp_ok;

   int checks = 0;
   int errors = 0;
   bit model_busy [NSESS];
   int tuple_n = 0;

   always #2.5 clk = ~clk;

   conn_req_ctrl dut_i (
      .clk(clk), .rst(rst),
      .open_req_valid(open_req_valid), .open_req_ready(open_req_ready),
      .open_req_addr(open_req_addr), .open_req_port(open_req_port),
      .open_rsp_valid(open_rsp_valid), .open_rsp_ready(open_rsp_ready),
      .open_rsp_sid(open_rsp_sid), .open_rsp_ok(open_rsp_ok),
      .close_req_valid(close_req_valid), .close_req_ready(close_req_ready),
      .close_req_sid(close_req_sid),
      .lsn_req_valid(lsn_req_valid), .lsn_req_ready(lsn_req_ready),
      .lsn_req_port(lsn_req_port),
      .lsn_rsp_valid(lsn_rsp_valid), .lsn_rsp_ready(lsn_rsp_ready),
      .lsn_rsp_ok(lsn_rsp_ok)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int model_lowest_free();
      for (int i = 0; i < NSESS; i++) if (!model_busy[i]) return i;
      return -1;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < NSESS; i++) model_busy[i] = 1'b0;
   endtask

   // issue an open, acknowledge at once, return result
   task automatic do_open(input logic [31:0] a, input logic [15:0] p,
                          output int sid, output int ok);
      @(negedge clk);
      while (!open_req_ready) @(negedge clk);
      open_req_valid = 1'b1; open_req_addr = a; open_req_port = p;
      @(negedge clk);
      open_req_valid = 1'b0;
      chk("R1 open rsp valid next cycle", int'(open_rsp_valid), 1);
      sid = int'(open_rsp_sid); ok = int'(open_rsp_ok);
      open_rsp_ready = 1'b1;
      @(negedge clk);
      open_rsp_ready = 1'b0;
      chk("R1 single open rsp", int'(open_rsp_valid), 0);
   endtask

   task automatic open_new_expect(input string tag);
      int sid, ok, exp;
      exp = model_lowest_free();
      tuple_n++;
      do_open(32'h0A00_0000 + tuple_n, 16'(1000 + tuple_n), sid, ok);
      if (exp < 0) begin
         chk({tag, " R3 full ok"}, ok, 0);
         chk({tag, " R3 full sid"}, sid, 0);
      end else begin
         chk({tag, " R2 ok"}, ok, 1);
         chk({tag, " R2 sid"}, sid, exp);
         model_busy[exp] = 1'b1;
      end
   endtask

   task automatic do_close(input int sid);
      @(negedge clk);
      chk("R5 close always ready", int'(close_req_ready), 1);
      close_req_valid = 1'b1; close_req_sid = 16'(sid);
      @(negedge clk);
      close_req_valid = 1'b0;
      chk("R5 close gives no open rsp", int'(open_rsp_valid), 0);
      if (sid < NSESS) model_busy[sid] = 1'b0;
   endtask

   task automatic do_listen(input logic [15:0] p, input int exp, input string tag);
      @(negedge clk);
      while (!lsn_req_ready) @(negedge clk);
      lsn_req_valid = 1'b1; lsn_req_port = p;
      @(negedge clk);
      lsn_req_valid = 1'b0;
      chk({tag, " R8 listen rsp valid"}, int'(lsn_rsp_valid), 1);
      chk(tag, int'(lsn_rsp_ok), exp);
      lsn_rsp_ready = 1'b1;
      @(negedge clk);
      lsn_rsp_ready = 1'b0;
   endtask

   task automatic t_reset();
      chk("R11 open rsp idle", int'(open_rsp_valid), 0);
      chk("R11 lsn rsp idle", int'(lsn_rsp_valid), 0);
      chk("R11 open ready", int'(open_req_ready), 1);
   endtask

   task automatic t_alloc();
      for (int i = 0; i < 3; i++) open_new_expect("alloc");
   endtask

   task automatic t_hold();
      int exp;
      exp = model_lowest_free();
      @(negedge clk);
      open_req_valid = 1'b1; open_req_addr = 32'hC0A8_0001; open_req_port = 16'd443;
      @(negedge clk);
      open_req_valid = 1'b0;
      for (int k = 0; k < 3; k++) begin
         chk("R1 hold valid", int'(open_rsp_valid), 1);
         chk("R1 hold sid", int'(open_rsp_sid), exp);
         chk("R1 no accept while pending", int'(open_req_ready), 0);
         @(negedge clk);
      end
      open_rsp_ready = 1'b1;
      @(negedge clk);
      open_rsp_ready = 1'b0;
      model_busy[exp] = 1'b1;
   endtask

   task automatic t_dup();
      int sid, ok;
      do_open(32'hC0A8_0001, 16'd443, sid, ok);
      chk("R4 dup ok", ok, 0);
      chk("R4 dup sid", sid, 0);
      open_new_expect("after dup R4");
   endtask

   task automatic t_close();
      do_close(1);
      open_new_expect("reuse R5");
   endtask

   task automatic t_full();
      while (model_lowest_free() >= 0) open_new_expect("fill");
      open_new_expect("full R3");
      do_close(24);
      do_close(16);
      open_new_expect("oob close R6");
      do_close(5);
      do_close(5);
      open_new_expect("double close R6");
      open_new_expect("refull R3");
   endtask

   task automatic t_listen();
      do_listen(16'd80, 1, "R8 new port");
      do_listen(16'd80, 0, "R9 repeat port");
      do_listen(16'd32768, 0, "R7 port 32768");
      do_listen(16'd65535, 0, "R7 port 65535");
      do_listen(16'd32767, 1, "R8 top in-range port");
      for (int i = 0; i < 6; i++) do_listen(16'(2000 + i), 1, "R10 fill slot");
      do_listen(16'd3000, 0, "R10 table full");
      do_listen(16'd80, 0, "R9 still listening");
   endtask

   task automatic t_reset2();
      do_reset();
      t_reset();
      do_listen(16'd80, 1, "R11 listen cleared");
      open_new_expect("R11 sessions cleared");
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      t_reset();
      t_alloc();
      t_hold();
      t_dup();
      t_close();
      t_full();
      t_listen();
      t_reset2();
      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule